// File: doc/BRIEF.md
# Sixteen-bit timer/counter with capture and reload

This block is a 16-bit timer/counter driven by a one-cycle machine-cycle strobe. It counts either on every strobe (timer) or on falling edges of an external count pin (counter). A single mode is active at any time. Capture mode copies the running count into a holding register when a trigger pin falls. Auto-reload mode reloads the count from the holding register, counting up or, with down-count enabled, in a direction set by the trigger pin. Baud mode reloads on every wrap and emits a serial-clock pulse.

The count and the capture/reload register are written one byte at a time through a select/data write port. A write to the flag location overwrites both flags. The overflow flag and the external flag stay set until software writes them. In down-count mode the external flag acts as a 17th count bit.

Top module: `tmr16_cap_rld`

## Requirements
- R1: In timer function (`ext_cnt_i`=0) with `run_i`=1, the count advances by one on each cycle where `tick_i`=1 and does not change on cycles where `tick_i`=0.
- R2: In counter function (`ext_cnt_i`=1), the count pin is sampled once per tick. A high sample followed by a low sample adds exactly one, and a pin held low across many ticks is counted only once.
- R3: In capture mode (`cap_sel_i`=1, both serial clock enables 0) with `ext_en_i`=1, a sampled falling edge of the trigger pin copies the pre-increment count into the capture/reload register and sets the external flag.
- R4: In capture mode the count wraps from FFFFh to 0000h and sets the overflow flag.
- R5: In up-counting auto-reload mode (`cap_sel_i`=0, `dn_en_i`=0), a step from FFFFh loads the reload value and sets the overflow flag.
- R6: In up-counting auto-reload mode with `ext_en_i`=1, a sampled falling edge of the trigger pin loads the reload value instead of stepping and sets the external flag.
- R7: With `dn_en_i`=1 in reload mode, a high trigger level counts up with reload on FFFFh. A low trigger level counts down, and a step taken when the count equals the reload value loads FFFFh. Both cases set the overflow flag.
- R8: With `dn_en_i`=1, the external flag toggles on every overflow and underflow, and trigger edges cause no reload.
- R9: With `rx_clk_en_i` or `tx_clk_en_i` set, a step from FFFFh loads the reload value and raises `baud_pulse_o` for one clock on the next cycle. The overflow flag is not set, and `cap_sel_i` is ignored.
- R10: After reset the count, the reload value, both flags and the pulse are 0. A set flag stays set until a write to select 4 loads it (bit 0 gives the overflow flag, bit 1 the external flag).
- R11: A write to count byte 0 (select 0, low byte) or 1 (select 1, high byte) takes priority over a step in the same cycle and leaves the other byte unchanged. Selects 2 and 3 write the low and high reload bytes.
- R12: With `run_i`=0 the count and the capture/reload register hold, regardless of ticks and pin edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Machine-cycle strobe |
| cnt_pin_i | input | 1 | External count pin |
| trig_pin_i | input | 1 | Trigger / direction pin |
| run_i | input | 1 | Run enable |
| ext_cnt_i | input | 1 | 1 = count pin edges, 0 = ticks |
| cap_sel_i | input | 1 | 1 = capture, 0 = auto-reload |
| ext_en_i | input | 1 | Enable trigger-pin events |
| dn_en_i | input | 1 | Enable up/down counting |
| rx_clk_en_i | input | 1 | Receive clock source enable |
| tx_clk_en_i | input | 1 | Transmit clock source enable |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | 0/1 count lo/hi, 2/3 reload lo/hi, 4 flags |
| wr_data_i | input | 8 | Write data |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Capture/reload register |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| baud_pulse_o | output | 1 | One-clock serial-clock pulse |

## Verification
Several properties are checked on every cycle. The count moves only on a tick or a write, and a stopped timer freezes both registers. The overflow flag never rises in baud mode, the pulse only follows a baud-mode cycle, and the flags are sticky. Exact arithmetic needs the bench's directed scenarios. These cover the capture value, reload values, the underflow compare against the reload register, the toggling external flag, edge counting of a held-low pin and write priority.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_BAUD,
    MODE_CAPTURE,
    MODE_RELOAD
  } tmr_mode_e;

  function automatic tmr_mode_e pick_mode(logic run, logic baud, logic cap);
    if (!run)      return MODE_OFF;
    else if (baud) return MODE_BAUD;
    else if (cap)  return MODE_CAPTURE;
    else           return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/tmr16_edge_smp.sv
module tmr16_edge_smp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic sync1_q, sync2_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (tick_i) last_q <= sync2_q;
    end
  end

  assign level_o = sync2_q;
  // high at previous tick, low at this tick
  assign fall_o  = tick_i & last_q & ~sync2_q;
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int NBYTES = CNT_W / BYTE_W,
  parameter int SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_fall_i,
  input  logic              trig_fall_i,
  input  logic              trig_lvl_i,
  input  logic              run_i,
  input  logic              ext_cnt_i,
  input  logic              cap_sel_i,
  input  logic              ext_en_i,
  input  logic              dn_en_i,
  input  logic              baud_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              ovf_o,
  output logic              ext_o,
  output logic              pulse_o
);
  localparam logic [CNT_W-1:0] ONES    = '1;
  localparam logic [SEL_W-1:0] SEL_FLG = SEL_W'(2 * NBYTES);

  logic [CNT_W-1:0] cnt_q, cnt_n, rld_q, rld_n;
  logic             ovf_q, ovf_n, ext_q, ext_n, pulse_q, pulse_n;
  logic             step, ovf_set, ext_set, ext_tgl, cnt_wr;
  tmr_mode_e        mode;

  assign mode = pick_mode(run_i, baud_i, cap_sel_i);
  assign step = ext_cnt_i ? cnt_fall_i : tick_i;

  always_comb begin
    cnt_n   = cnt_q;
    rld_n   = rld_q;
    ovf_set = 1'b0;
    ext_set = 1'b0;
    ext_tgl = 1'b0;
    pulse_n = 1'b0;
    unique case (mode)
      MODE_BAUD: begin
        if (step) begin
          if (cnt_q == ONES) begin
            cnt_n   = rld_q;
            pulse_n = 1'b1;
          end else cnt_n = cnt_q + 1'b1;
        end
      end
      MODE_CAPTURE: begin
        if (step) begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == ONES) ovf_set = 1'b1;
        end
        if (ext_en_i && trig_fall_i) begin
          rld_n   = cnt_q;
          ext_set = 1'b1;
        end
      end
      MODE_RELOAD: begin
        if (dn_en_i) begin
          if (step) begin
            if (trig_lvl_i) begin
              if (cnt_q == ONES) begin
                cnt_n = rld_q; ovf_set = 1'b1; ext_tgl = 1'b1;
              end else cnt_n = cnt_q + 1'b1;
            end else begin
              if (cnt_q == rld_q) begin
                cnt_n = ONES; ovf_set = 1'b1; ext_tgl = 1'b1;
              end else cnt_n = cnt_q - 1'b1;
            end
          end
        end else if (ext_en_i && trig_fall_i) begin
          cnt_n   = rld_q;
          ext_set = 1'b1;
        end else if (step) begin
          if (cnt_q == ONES) begin
            cnt_n   = rld_q;
            ovf_set = 1'b1;
          end else cnt_n = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase

    // software byte writes win over hardware updates
    cnt_wr = 1'b0;
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en_i && wr_sel_i == SEL_W'(b)) begin
        cnt_wr = 1'b1;
        cnt_n  = cnt_q;
      end
    end
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en_i && wr_sel_i == SEL_W'(b))
        cnt_n[b*BYTE_W +: BYTE_W] = wr_data_i;
      if (wr_en_i && wr_sel_i == SEL_W'(NBYTES + b))
        rld_n[b*BYTE_W +: BYTE_W] = wr_data_i;
    end
    if (cnt_wr) pulse_n = 1'b0;

    if (wr_en_i && wr_sel_i == SEL_FLG) begin
      ovf_n = wr_data_i[0];
      ext_n = wr_data_i[1];
    end else begin
      ovf_n = ovf_q | ovf_set;
      ext_n = ext_tgl ? ~ext_q : (ext_q | ext_set);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rld_q   <= '0;
      ovf_q   <= 1'b0;
      ext_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      rld_q   <= rld_n;
      ovf_q   <= ovf_n;
      ext_q   <= ext_n;
      pulse_q <= pulse_n;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
  assign ovf_o    = ovf_q;
  assign ext_o    = ext_q;
  assign pulse_o  = pulse_q;
endmodule

// File: rtl/tmr16_cap_rld.sv
module tmr16_cap_rld #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int SEL_W  = $clog2(2 * NBYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              run_i,
  input  logic              ext_cnt_i,
  input  logic              cap_sel_i,
  input  logic              ext_en_i,
  input  logic              dn_en_i,
  input  logic              rx_clk_en_i,
  input  logic              tx_clk_en_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              baud_pulse_o
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_fall;
  assign pin_raw = {trig_pin_i, cnt_pin_i};

  for (genvar i = 0; i < NPIN; i++) begin : g_smp
    tmr16_edge_smp u_smp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .pin_i  (pin_raw[i]),
      .level_o(pin_lvl[i]),
      .fall_o (pin_fall[i])
    );
  end

  logic unused_lvl;
  assign unused_lvl = pin_lvl[0];

  tmr16_core #(
    .CNT_W (CNT_W),
    .BYTE_W(BYTE_W),
    .NBYTES(NBYTES),
    .SEL_W (SEL_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cnt_fall_i (pin_fall[0]),
    .trig_fall_i(pin_fall[1]),
    .trig_lvl_i (pin_lvl[1]),
    .run_i      (run_i),
    .ext_cnt_i  (ext_cnt_i),
    .cap_sel_i  (cap_sel_i),
    .ext_en_i   (ext_en_i),
    .dn_en_i    (dn_en_i),
    .baud_i     (rx_clk_en_i | tx_clk_en_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .count_o    (count_o),
    .reload_o   (reload_o),
    .ovf_o      (ovf_flag_o),
    .ext_o      (ext_flag_o),
    .pulse_o    (baud_pulse_o)
  );
endmodule

// File: rtl/tmr16_cap_rld_chk.sv
module tmr16_cap_rld_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              run_i,
  input logic              dn_en_i,
  input logic              rx_clk_en_i,
  input logic              tx_clk_en_i,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [CNT_W-1:0]  reload_o,
  input logic              ovf_flag_o,
  input logic              ext_flag_o,
  input logic              baud_pulse_o
);
  localparam logic [SEL_W-1:0] SEL_FLG = SEL_W'(2 * (CNT_W / BYTE_W));

  logic flag_wr, baud;
  assign flag_wr = wr_en_i && (wr_sel_i == SEL_FLG);
  assign baud    = rx_clk_en_i | tx_clk_en_i;

  AST_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(count_o)); // R1
  AST_BAUD_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud && !ovf_flag_o && !flag_wr) |=> !ovf_flag_o); // R9
  AST_PULSE_BAUD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(baud_pulse_o) |-> $past(baud)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !flag_wr) |=> ovf_flag_o); // R10
  AST_EXT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_flag_o && !flag_wr && !dn_en_i) |=> ext_flag_o); // R10
  AST_RUN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> ($stable(count_o) && $stable(reload_o))); // R12
endmodule

bind tmr16_cap_rld tmr16_cap_rld_chk #(
  .CNT_W (CNT_W),
  .BYTE_W(BYTE_W),
  .SEL_W (SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .run_i       (run_i),
  .dn_en_i     (dn_en_i),
  .rx_clk_en_i (rx_clk_en_i),
  .tx_clk_en_i (tx_clk_en_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .count_o     (count_o),
  .reload_o    (reload_o),
  .ovf_flag_o  (ovf_flag_o),
  .ext_flag_o  (ext_flag_o),
  .baud_pulse_o(baud_pulse_o)
);

// File: tb/tmr16_cap_rld_bench.sv
module tmr16_cap_rld_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
  logic        run = 1'b0, ext_cnt = 1'b0, cap_sel = 1'b0, ext_en = 1'b0, dn_en = 1'b0;
  logic        rx_en = 1'b0, tx_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count, reload;
  logic        ovf, ext, pulse;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tmr16_cap_rld u_tmr16_cap_rld (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cnt_pin_i(cnt_pin),
    .trig_pin_i(trig_pin), .run_i(run), .ext_cnt_i(ext_cnt), .cap_sel_i(cap_sel),
    .ext_en_i(ext_en), .dn_en_i(dn_en), .rx_clk_en_i(rx_en), .tx_clk_en_i(tx_en),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .count_o(count),
    .reload_o(reload), .ovf_flag_o(ovf), .ext_flag_o(ext), .baud_pulse_o(pulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(3'd0, v[7:0]); wr(3'd1, v[15:8]);
  endtask

  task automatic set_rld(logic [15:0] v);
    wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pin_cnt(logic v);
    cnt_pin = v; repeat (3) @(negedge clk);
  endtask

  task automatic pin_trig(logic v);
    trig_pin = v; repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 count", count, 0);
    check("R10 reload", reload, 0);
    check("R10 flags", {ovf, ext, pulse}, 0);
  endtask

  task automatic t_timer;
    run = 1'b1; ext_cnt = 1'b0; cap_sel = 1'b0; ext_en = 1'b0;
    set_cnt(16'h1234);
    ticks(5);
    check("R1 five ticks", count, 16'h1239);
    repeat (6) @(negedge clk);
    check("R1 no tick", count, 16'h1239);
  endtask

  task automatic t_counter;
    ext_cnt = 1'b1;
    set_cnt(16'h0000);
    ticks(3);
    check("R2 pin high", count, 0);
    pin_cnt(1'b0); ticks(1);
    check("R2 first fall", count, 1);
    ticks(4);
    check("R2 held low", count, 1);
    pin_cnt(1'b1); ticks(2);
    pin_cnt(1'b0); ticks(1);
    check("R2 second fall", count, 2);
    pin_cnt(1'b1); ticks(1);
    ext_cnt = 1'b0;
  endtask

  task automatic t_capture;
    cap_sel = 1'b1; ext_en = 1'b1;
    set_cnt(16'h0100);
    ticks(2);
    pin_trig(1'b0); ticks(1);
    check("R3 captured", reload, 16'h0102);
    check("R3 count", count, 16'h0103);
    check("R3 ext flag", ext, 1);
    pin_trig(1'b1); ticks(1);
    set_cnt(16'hFFFE);
    ticks(1);
    check("R4 no ovf yet", ovf, 0);
    ticks(1);
    check("R4 wrap", count, 0);
    check("R4 ovf flag", ovf, 1);
  endtask

  task automatic t_flags;
    ticks(2);
    check("R10 sticky", {ovf, ext}, 2'b11);
    wr(3'd4, 8'h00);
    check("R10 sw clear", {ovf, ext}, 2'b00);
  endtask

  task automatic t_reload;
    cap_sel = 1'b0; ext_en = 1'b1; dn_en = 1'b0;
    set_rld(16'hFFF0);
    set_cnt(16'hFFFD);
    ticks(2);
    check("R5 at top", count, 16'hFFFF);
    check("R5 no ovf", ovf, 0);
    ticks(1);
    check("R5 reloaded", count, 16'hFFF0);
    check("R5 ovf", ovf, 1);
    set_cnt(16'h0005);
    pin_trig(1'b0); ticks(1);
    check("R6 trig reload", count, 16'hFFF0);
    check("R6 ext", ext, 1);
    pin_trig(1'b1); ticks(1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_down;
    dn_en = 1'b1; ext_en = 1'b1;
    set_rld(16'h0010);
    set_cnt(16'h0012);
    pin_trig(1'b0);
    ticks(2);
    check("R7 down", count, 16'h0010);
    check("R8 no toggle yet", ext, 0);
    check("R8 no trig reload", reload, 16'h0010);
    ticks(1);
    check("R7 underflow", count, 16'hFFFF);
    check("R7 ovf", ovf, 1);
    check("R8 toggled", ext, 1);
    pin_trig(1'b1); ticks(1);
    check("R7 up reload", count, 16'h0010);
    check("R8 toggled back", ext, 0);
    dn_en = 1'b0; ext_en = 1'b0;
    wr(3'd4, 8'h00);
  endtask

  task automatic t_baud;
    rx_en = 1'b1; cap_sel = 1'b1;
    set_rld(16'hFFFE);
    set_cnt(16'hFFFF);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R9 reload", count, 16'hFFFE);
    check("R9 pulse", pulse, 1);
    check("R9 no ovf", ovf, 0);
    @(negedge clk);
    check("R9 pulse ends", pulse, 0);
    ticks(1);
    check("R9 step", count, 16'hFFFF);
    check("R9 no pulse", pulse, 0);
    rx_en = 1'b0; tx_en = 1'b1;
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check("R9 tx pulse", pulse, 1);
    @(negedge clk);
    tx_en = 1'b0; cap_sel = 1'b0;
  endtask

  task automatic t_stop;
    run = 1'b0; cap_sel = 1'b1; ext_en = 1'b1;
    set_cnt(16'h0777);
    set_rld(16'h0123);
    ticks(4);
    pin_trig(1'b0); ticks(1); pin_trig(1'b1); ticks(1);
    check("R12 count held", count, 16'h0777);
    check("R12 reload held", reload, 16'h0123);
    cap_sel = 1'b0; ext_en = 1'b0; run = 1'b1;
  endtask

  task automatic t_prio;
    set_cnt(16'h20FF);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h55;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R11 write wins", count, 16'h2055);
    ticks(1);
    check("R11 then steps", count, 16'h2056);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_counter();
    t_capture();
    t_flags();
    t_reload();
    t_down();
    t_baud();
    t_stop();
    t_prio();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule